// File: doc/BRIEF.md
# OTP Packet Directory Scanner

This block walks the packet chain stored in a one-time-programmable array and builds a directory of where each packet begins. Every packet starts with a header word whose bits 15:8 hold the payload length in words. The scanner reads the header at the current word position and records that position under the next packet number. It then adds the packet's byte footprint to a running total and jumps to the following header. The walk ends at a header whose length field is zero, once the byte total reaches a fixed ceiling, when the directory has no free slot, or when a read never completes.

The scan starts on its own when reset is released. A start pulse repeats it after a finished scan. The downstream controller takes read requests over a valid/ready handshake. The block holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen high at a clock edge. The controller then keeps `mem_busy` high until the header is available. The first cycle after acceptance in which `mem_busy` is low is the cycle in which `mem_hdr` is sampled. The block has no back-pressure input of its own: results stay on plain status pins, and the lookup port answers combinationally at any time.

Top module: `otp_dir_scan`

## Requirements
- R1: After reset is released the scan starts by itself. The first request carries word address 0, and packets are numbered 0, 1, 2, … in the order they are found.
- R2: `mem_req_valid` stays high with `mem_req_addr` unchanged until `mem_req_ready` is high at a rising edge. The header is taken in the first later cycle with `mem_busy` low.
- R3: Only header bits 15:8 form the length field. A zero length ends the scan without counting that packet, whatever the other header bits hold.
- R4: Each counted packet of length L adds 4·(L+1) to `total_bytes`. The next request address is the previous one plus L+2.
- R5: Before each read the byte total is compared with LIMIT_BYTES (default 11264). At or above it, the scan ends without issuing the read.
- R6: A lookup with `lk_id` below `pkt_count` gives `lk_valid`=1 and that packet's start word on `lk_offset`. Otherwise `lk_valid`=0 and `lk_offset`=0.
- R7: A read not completed within TIMEOUT cycles (default 64), counted from the first cycle its request is raised, ends the scan with `err_timeout`=1.
- R8: The directory holds ENTRIES packets (default 16). A nonzero header met while it is full ends the scan with `err_full`=1, and the count stays at ENTRIES. A zero header at that point ends the scan cleanly.
- R9: `scan_done` rises when the scan ends and stays high until a start pulse. A start pulse while done clears the results and rescans from word 0. A start pulse during a scan has no effect.
- R10: While reset is held: `scan_done`, `mem_req_valid`, both error flags and `lk_valid` are 0, and `pkt_count` and `total_bytes` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Rescan pulse, honoured only while done |
| mem_req_valid | output | 1 | Header read request |
| mem_req_ready | input | 1 | Controller accepts the request |
| mem_req_addr | output | ADDR_W | Word address of the header |
| mem_busy | input | 1 | Read in progress after acceptance |
| mem_hdr | input | 32 | Header word, valid when busy is low |
| scan_done | output | 1 | Scan finished |
| err_timeout | output | 1 | Scan ended by a read timeout |
| err_full | output | 1 | Scan ended with the directory full |
| pkt_count | output | CNT_W | Packets recorded |
| total_bytes | output | BYTES_W | Accumulated byte size |
| lk_id | input | CNT_W | Packet number to look up |
| lk_valid | output | 1 | Lookup hit |
| lk_offset | output | ADDR_W | Start word of the looked-up packet |

## Verification
A wrong word position or a corrupted length shows on the very next `mem_req_addr`, one cycle after the header is taken. The bench catches it by logging every accepted address against an independently walked layout. A wrong directory write or count shows only through lookups, which are swept over every recorded number and one past the end after each scan. Stop-condition faults (limit, full, timeout, zero header) change how many reads are issued and which flag is set when `scan_done` rises. These are compared per scenario.

// File: rtl/otp_dir_pkg.sv
package otp_dir_pkg;
  typedef enum logic [1:0] {
    ST_CHECK = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } scan_state_t;

  // header length field position, decoded by the walk
  localparam int HDR_LEN_LSB = 8;
  localparam int HDR_LEN_W   = 8;
endpackage

// File: rtl/otp_scan_timer.sv
module otp_scan_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int TMR_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT - 1);

  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (en && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);

  AST_TMR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !clr |=> expired); // R7
endmodule

// File: rtl/otp_dir_table.sv
module otp_dir_table #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 16,
  localparam int ID_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ID_W-1:0]   widx,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [ID_W-1:0]   ridx,
  output logic [ADDR_W-1:0] rdata
);
  logic [ADDR_W-1:0] slot [ENTRIES];
  logic [ENTRIES-1:0] wsel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
    assign wsel[g] = we && (widx == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (wsel[i]) slot[i] <= wdata;
    end
  end

  assign rdata = slot[ridx];

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel)); // R6
endmodule

// File: rtl/otp_dir_scan.sv
module otp_dir_scan
  import otp_dir_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ENTRIES     = 16,
  parameter int BYTES_W     = 16,
  parameter int LIMIT_BYTES = 11264,
  parameter int TIMEOUT     = 64,
  localparam int CNT_W      = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_busy,
  input  logic [31:0]        mem_hdr,
  output logic               scan_done,
  output logic               err_timeout,
  output logic               err_full,
  output logic [CNT_W-1:0]   pkt_count,
  output logic [BYTES_W-1:0] total_bytes,
  input  logic [CNT_W-1:0]   lk_id,
  output logic               lk_valid,
  output logic [ADDR_W-1:0]  lk_offset
);
  localparam int ID_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [BYTES_W-1:0] LIMIT_V = BYTES_W'(LIMIT_BYTES);
  localparam logic [CNT_W-1:0]   FULL_V  = CNT_W'(ENTRIES);

  scan_state_t          state;
  logic [ADDR_W-1:0]    pos;
  logic [CNT_W-1:0]     count;
  logic [BYTES_W-1:0]   total;
  logic                 to_q, full_q;
  logic [HDR_LEN_W-1:0] hlen;
  logic                 rd_done, tbl_we, tmr_exp;
  logic [BYTES_W-1:0]   pkt_bytes;
  logic [ADDR_W-1:0]    next_pos;
  logic [ADDR_W-1:0]    tbl_rdata;
  logic                 unused_hdr;

  assign hlen       = mem_hdr[HDR_LEN_LSB +: HDR_LEN_W];
  assign unused_hdr = ^{mem_hdr[31:HDR_LEN_LSB+HDR_LEN_W], mem_hdr[HDR_LEN_LSB-1:0]};
  assign rd_done    = (state == ST_WAIT) && !mem_busy;
  assign tbl_we     = rd_done && (hlen != '0) && (count != FULL_V);
  assign pkt_bytes  = BYTES_W'({hlen, 2'b00}) + BYTES_W'(4);
  assign next_pos   = pos + ADDR_W'(hlen) + ADDR_W'(2);

  otp_scan_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == ST_CHECK),
    .en      ((state == ST_REQ) || (state == ST_WAIT)),
    .expired (tmr_exp)
  );

  otp_dir_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .widx  (count[ID_W-1:0]),
    .wdata (pos),
    .ridx  (lk_id[ID_W-1:0]),
    .rdata (tbl_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_CHECK;
      pos    <= '0;
      count  <= '0;
      total  <= '0;
      to_q   <= 1'b0;
      full_q <= 1'b0;
    end else begin
      unique case (state)
        ST_CHECK: state <= (total >= LIMIT_V) ? ST_DONE : ST_REQ;
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
          else if (tmr_exp) begin
            state <= ST_DONE;
            to_q  <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (!mem_busy) begin
            if (hlen == '0) state <= ST_DONE;
            else if (count == FULL_V) begin
              state  <= ST_DONE;
              full_q <= 1'b1;
            end else begin
              count <= count + 1'b1;
              total <= total + pkt_bytes;
              pos   <= next_pos;
              state <= ST_CHECK;
            end
          end else if (tmr_exp) begin
            state <= ST_DONE;
            to_q  <= 1'b1;
          end
        end
        ST_DONE: begin
          if (start) begin
            state  <= ST_CHECK;
            pos    <= '0;
            count  <= '0;
            total  <= '0;
            to_q   <= 1'b0;
            full_q <= 1'b0;
          end
        end
        default: state <= ST_CHECK;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = pos;
  assign scan_done     = (state == ST_DONE);
  assign err_timeout   = to_q;
  assign err_full      = full_q;
  assign pkt_count     = count;
  assign total_bytes   = total;
  assign lk_valid      = (lk_id < count);
  assign lk_offset     = lk_valid ? tbl_rdata : '0;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !tmr_exp |=> mem_req_valid && $stable(mem_req_addr)); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done && !start |=> scan_done && $stable(pkt_count) && $stable(total_bytes)); // R9
  AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !mem_req_valid); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count <= FULL_V); // R8
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_timeout && err_full)); // R8
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout || err_full) |-> scan_done); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> pkt_count == $past(pkt_count) + 1'b1); // R4
endmodule

// File: tb/otp_dir_scan_test.sv
`timescale 1ns/1ps
module otp_dir_scan_test;
  localparam int ADDR_W = 16, ENTRIES = 16, BYTES_W = 16, LIMIT = 11264, TOUT = 64;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  typedef struct packed {
    int n; int base; int step; int lat; int rdly; int ecnt; int efull;
  } scen_t;

  // n packets of length base+i*step, then zero header; expected count/full
  localparam scen_t SCN [6] = '{
    '{3,   1,  1, 0, 0,  3, 0},
    '{5,  10,  5, 3, 2,  5, 0},
    '{0,   1,  0, 1, 0,  0, 0},
    '{20, 255, 0, 1, 1, 11, 0},
    '{17,  2,  0, 2, 0, 16, 1},
    '{16,  3,  0, 0, 1, 16, 0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic mem_req_valid, mem_req_ready = 0, mem_busy = 0;
  logic [ADDR_W-1:0] mem_req_addr, lk_offset;
  logic [31:0] mem_hdr = 32'hFFFF_00FF;
  logic scan_done, err_timeout, err_full, lk_valid;
  logic [CNT_W-1:0] pkt_count, lk_id = '0;
  logic [BYTES_W-1:0] total_bytes;

  always #4 clk = ~clk;

  otp_dir_scan #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .BYTES_W(BYTES_W),
                 .LIMIT_BYTES(LIMIT), .TIMEOUT(TOUT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_busy(mem_busy), .mem_hdr(mem_hdr),
    .scan_done(scan_done), .err_timeout(err_timeout), .err_full(err_full),
    .pkt_count(pkt_count), .total_bytes(total_bytes),
    .lk_id(lk_id), .lk_valid(lk_valid), .lk_offset(lk_offset));

  int n_chk = 0, n_fail = 0;
  int cur_n = 0, cur_base = 0, cur_step = 0, cur_lat = 0, cur_rdly = 0;
  bit hang = 0;
  int addr_log [32];
  int nlog = 0;
  int exp_start [32];
  int m_cnt, m_tot, m_full, m_reads;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input int i);
    return (i < cur_n) ? (cur_base + i * cur_step) : 0;
  endfunction

  // header word at a word address; junk outside bits 15:8 (R3)
  function automatic logic [31:0] hdr_at(input int addr);
    int p = 0;
    for (int i = 0; i < 32; i++) begin
      if (addr == p) return {16'hA5C3, len_of(i) [7:0], 8'hE7};
      if (len_of(i) == 0) break;
      p += len_of(i) + 2;
    end
    return 32'hFFFF_00FF;
  endfunction

  // walk built from the requirements
  task automatic model();
    int pos = 0;
    m_cnt = 0; m_tot = 0; m_full = 0; m_reads = 0;
    while (1) begin
      if (m_tot >= LIMIT) break;
      m_reads++;
      if (len_of(m_cnt) == 0) break;
      if (m_cnt == ENTRIES) begin m_full = 1; break; end
      exp_start[m_cnt] = pos;
      m_tot += 4 * (len_of(m_cnt) + 1);
      pos += len_of(m_cnt) + 2;
      m_cnt++;
    end
  endtask

  // controller model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        int a;
        for (int k = 0; k < cur_rdly; k++) begin
          mem_req_ready = 0;
          @(negedge clk);
        end
        mem_req_ready = 1;
        a = int'(mem_req_addr);
        @(negedge clk);
        mem_req_ready = 0;
        if (nlog < 32) addr_log[nlog] = a;
        nlog++;
        if (cur_lat > 0 || hang) begin
          mem_busy = 1;
          mem_hdr = 32'hDEAD_BEEF;
          for (int k = 1; k < cur_lat; k++) @(negedge clk);
          while (hang) @(negedge clk);
          @(negedge clk);
        end
        mem_busy = 0;
        mem_hdr = hdr_at(a);
      end
    end
  end

  task automatic load(input int s);
    cur_n = SCN[s].n; cur_base = SCN[s].base; cur_step = SCN[s].step;
    cur_lat = SCN[s].lat; cur_rdly = SCN[s].rdly;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!scan_done && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic check_result(input string tag, input int ecnt, input int efull);
    model();
    chk(scan_done == 1, "R9 done", int'(scan_done), 1);
    chk(int'(pkt_count) == m_cnt && m_cnt == ecnt, {tag, " R3 count"}, int'(pkt_count), ecnt);
    chk(int'(total_bytes) == m_tot, {tag, " R4 total"}, int'(total_bytes), m_tot);
    chk(int'(err_full) == efull && m_full == efull, {tag, " R8 full flag"}, int'(err_full), efull);
    chk(err_timeout == 0, {tag, " R7 no timeout"}, int'(err_timeout), 0);
    chk(nlog == m_reads, {tag, " R5 read count"}, nlog, m_reads);
    for (int i = 0; i < m_cnt && i < nlog; i++)
      chk(addr_log[i] == exp_start[i], {tag, " R4 address"}, addr_log[i], exp_start[i]);
    for (int i = 0; i <= m_cnt && i <= ENTRIES; i++) begin
      lk_id = CNT_W'(i);
      #1;
      if (i < m_cnt) begin
        chk(lk_valid == 1, {tag, " R6 lookup hit"}, int'(lk_valid), 1);
        chk(int'(lk_offset) == exp_start[i], {tag, " R6 lookup offset"}, int'(lk_offset), exp_start[i]);
      end else if (i < ENTRIES + 1) begin
        chk(lk_valid == 0 && lk_offset == '0, {tag, " R6 lookup miss"}, int'(lk_valid), 0);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    load(0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(scan_done == 0 && mem_req_valid == 0, "R10 done/valid", int'(scan_done), 0);
    chk(pkt_count == 0 && total_bytes == 0, "R10 count/total", int'(pkt_count), 0);
    chk(err_timeout == 0 && err_full == 0 && lk_valid == 0, "R10 flags", int'(err_full), 0);
    rst_n = 1;
    // R1 auto start from word 0
    wait_done();
    chk(nlog > 0 && addr_log[0] == 0, "R1 first address", addr_log[0], 0);
    check_result("S0 R1", SCN[0].ecnt, SCN[0].efull);

    // vector table walk
    for (int s = 1; s < 6; s++) begin
      load(s);
      nlog = 0;
      pulse_start();
      wait_done();
      check_result($sformatf("S%0d", s), SCN[s].ecnt, SCN[s].efull);
    end

    // R9 done stays high, results stable
    repeat (10) @(negedge clk);
    chk(scan_done == 1 && pkt_count == CNT_W'(16), "R9 sticky", int'(pkt_count), 16);

    // R9 start during a scan is ignored
    load(1); cur_lat = 4;
    nlog = 0;
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    wait_done();
    check_result("R9 mid-start", 5, 0);

    // R7 timeout on a read that never completes
    load(0);
    hang = 1;
    nlog = 0;
    pulse_start();
    wait_done();
    chk(err_timeout == 1 && err_full == 0, "R7 timeout flag", int'(err_timeout), 1);
    chk(pkt_count == 0, "R7 count on timeout", int'(pkt_count), 0);
    hang = 0;
    repeat (4) @(negedge clk);

    // R2 stalled handshake then recovery after timeout
    load(0); cur_rdly = 5;
    nlog = 0;
    pulse_start();
    wait_done();
    check_result("R2 stall", 3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule